// File: doc/BRIEF.md
# Tagged-Operand Reservation Station Pool

This block sits in front of a single arithmetic unit in an out-of-order datapath. Each incoming instruction takes a free station. Each of its two source operands arrives either as a finished value or as the tag of the station that will produce it. A station with a pending operand watches the shared result bus. When the bus carries that tag, the station copies the value and marks the operand present. The two operands fill in independently. A station whose operands are both present becomes a candidate for execution. Among the candidates, the one allocated earliest is sent to the unit.

The unit computes the result in one cycle and holds it on a valid/ready output with the producing station's tag. An external arbiter grants that output onto the shared bus. The station is freed in the cycle the result is accepted. The issue side is valid/ready: `iss_ready` reports that at least one station is free and never depends on `iss_valid`. An instruction is taken on a cycle where both are high. An offered instruction may be held for any number of cycles. On the result side, once `res_valid` rises it stays high, with tag and value unchanged, until a cycle where `res_ready` is high. The bus input is observe-only and has no back-pressure. The environment places the pool's own accepted result on that bus in the same cycle.

Top module: `rs_pool`

## Requirements
- R1: After reset every station is free, `iss_ready` is 1 and `res_valid` is 0.
- R2: An instruction is accepted only on a cycle with `iss_valid` and `iss_ready` both high. `iss_ready` is 0 exactly when every station is busy, and an instruction offered meanwhile is held and not lost.
- R3: An operand tag of 0 means the value field is already valid. Station i (counted from 0) owns the nonzero tag TAG_BASE+i, and every result leaves carrying its station's tag.
- R4: A waiting operand takes the bus value on a cycle where `bus_valid` is 1 and `bus_tag` equals its tag. Each operand does this on its own. A bus tag matching neither operand has no effect.
- R5: If the bus carries a tag in the same cycle that an instruction waiting on that tag is accepted, the value is captured at allocation.
- R6: A station is sent to the unit only once both operands hold values. Its result appears on `res_valid` in the cycle after dispatch.
- R7: When several stations are ready together, the earliest allocated goes first. The lowest index wins only when ages cannot be told apart.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_tag` and `res_data` stay unchanged.
- R9: A station is freed on the cycle its result is accepted, and may be allocated again from the next cycle.
- R10: Operation codes are 0 add (a+b), 1 subtract (a-b), 2 bitwise AND, 3 bitwise OR, 4 bitwise XOR. Codes 5 to 7 pass operand a through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered |
| iss_ready | output | 1 | A station is free |
| iss_op | input | 3 | Operation code |
| iss_a_val | input | DATA_W | Operand a value (used when its tag is 0) |
| iss_a_tag | input | TAG_W | Operand a producer tag, 0 if present |
| iss_b_val | input | DATA_W | Operand b value (used when its tag is 0) |
| iss_b_tag | input | TAG_W | Operand b producer tag, 0 if present |
| bus_valid | input | 1 | Shared result bus carries a result |
| bus_tag | input | TAG_W | Tag of the result on the bus |
| bus_data | input | DATA_W | Value on the bus |
| res_valid | output | 1 | Result waiting for the bus |
| res_ready | input | 1 | Bus grant for this pool's result |
| res_tag | output | TAG_W | Producing station's tag |
| res_data | output | DATA_W | Computed value |

## Verification
The bench uses the defaults: four stations, 32-bit data, 4-bit tags starting at 1. With only four stations, a handful of waiting instructions fills the pool, so stalls and the reuse of freed stations both come into play. Tags 9 to 14 lie outside the pool's range and serve as foreign producers on the bus. The bench's own arbiter withholds the grant while a foreign tag is broadcast. This lets it stage same-cycle capture at issue, a re-allocated low-index station competing against an older higher-index one, and a result held under back-pressure.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_ADD = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB = 3'd1;
  localparam logic [OP_W-1:0] OP_AND = 3'd2;
  localparam logic [OP_W-1:0] OP_OR  = 3'd3;
  localparam logic [OP_W-1:0] OP_XOR = 3'd4;
endpackage

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              dispatch,
  input  logic              release_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  logic              busy_q, sent_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic [TAG_W-1:0]  a_wait_q, b_wait_q;

  // snoop matches for a new instruction and for the held operands
  logic new_a_hit, new_b_hit, a_hit, b_hit;
  assign new_a_hit = bus_valid && (iss_a_tag != '0) && (bus_tag == iss_a_tag);
  assign new_b_hit = bus_valid && (iss_b_tag != '0) && (bus_tag == iss_b_tag);
  assign a_hit     = bus_valid && (a_wait_q != '0) && (bus_tag == a_wait_q);
  assign b_hit     = bus_valid && (b_wait_q != '0) && (bus_tag == b_wait_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sent_q   <= 1'b0;
      op_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      a_wait_q <= '0;
      b_wait_q <= '0;
    end else if (alloc) begin
      busy_q   <= 1'b1;
      sent_q   <= 1'b0;
      op_q     <= iss_op;
      a_q      <= new_a_hit ? bus_data : iss_a_val;
      a_wait_q <= new_a_hit ? '0 : iss_a_tag;
      b_q      <= new_b_hit ? bus_data : iss_b_val;
      b_wait_q <= new_b_hit ? '0 : iss_b_tag;
    end else begin
      if (release_i) begin
        busy_q <= 1'b0;
        sent_q <= 1'b0;
      end else if (dispatch) begin
        sent_q <= 1'b1;
      end
      if (busy_q && a_hit) begin
        a_q      <= bus_data;
        a_wait_q <= '0;
      end
      if (busy_q && b_hit) begin
        b_q      <= bus_data;
        b_wait_q <= '0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && !sent_q && (a_wait_q == '0) && (b_wait_q == '0);
  assign op_o    = op_q;
  assign a_o     = a_q;
  assign b_o     = b_q;

  // R6: a dispatched station has both operands present
  assert_fire_with_values_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> (busy_q && a_wait_q == '0 && b_wait_q == '0));
endmodule

// File: rtl/rs_age.sv
module rs_age #(
  parameter int NUM_RS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_RS-1:0] alloc_vec,
  input  logic [NUM_RS-1:0] req_vec,
  output logic [NUM_RS-1:0] grant_vec
);
  // older_q[i][j] set: station i was allocated before station j
  logic [NUM_RS-1:0][NUM_RS-1:0] older_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < NUM_RS; i++) begin
        for (int j = 0; j < NUM_RS; j++) begin
          if (alloc_vec[i])
            older_q[i][j] <= 1'b0;
          else if (alloc_vec[j] && i != j)
            older_q[i][j] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_RS; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < NUM_RS; j++) begin
        if (j != i && req_vec[j] && (older_q[j][i] || (!older_q[i][j] && j < i)))
          beaten = 1'b1;
      end
      grant_vec[i] = req_vec[i] && !beaten;
    end
  end

  assert_single_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));
  assert_someone_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vec != '0) |-> (grant_vec != '0));
endmodule

// File: rtl/rs_exec.sv
module rs_exec
  import rs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [TAG_W-1:0]  tag,
  input  logic [IDX_W-1:0]  idx,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data,
  output logic [IDX_W-1:0]  res_idx
);
  logic [DATA_W-1:0] alu_out;

  always_comb begin
    case (op)
      OP_ADD:  alu_out = a + b;
      OP_SUB:  alu_out = a - b;
      OP_AND:  alu_out = a & b;
      OP_OR:   alu_out = a | b;
      OP_XOR:  alu_out = a ^ b;
      default: alu_out = a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_tag   <= '0;
      res_data  <= '0;
      res_idx   <= '0;
    end else if (fire) begin
      res_valid <= 1'b1;
      res_tag   <= tag;
      res_data  <= alu_out;
      res_idx   <= idx;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_hold_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_tag) && $stable(res_data)));
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int NUM_RS   = 4,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int TAG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [2:0]        iss_op,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data
);
  localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

  logic [NUM_RS-1:0] busy_vec, ready_vec, alloc_vec, grant_vec, disp_vec, rel_vec;
  logic [OP_W-1:0]   op_arr [NUM_RS];
  logic [DATA_W-1:0] a_arr  [NUM_RS];
  logic [DATA_W-1:0] b_arr  [NUM_RS];
  logic [IDX_W-1:0]  ex_idx;
  logic              fire;
  logic [OP_W-1:0]   sel_op;
  logic [DATA_W-1:0] sel_a, sel_b;
  logic [IDX_W-1:0]  sel_idx;
  logic [TAG_W-1:0]  sel_tag;

  // allocation: lowest-index free station
  assign iss_ready = ~&busy_vec;
  always_comb begin
    logic found;
    found     = 1'b0;
    alloc_vec = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (!busy_vec[i] && !found) begin
        found        = 1'b1;
        alloc_vec[i] = iss_valid;
      end
    end
  end

  rs_age #(.NUM_RS(NUM_RS)) age_i (
    .clk(clk), .rst_n(rst_n), .alloc_vec(alloc_vec),
    .req_vec(ready_vec), .grant_vec(grant_vec)
  );

  assign fire     = (grant_vec != '0) && (!res_valid || res_ready);
  assign disp_vec = fire ? grant_vec : '0;

  always_comb begin
    sel_op  = '0;
    sel_a   = '0;
    sel_b   = '0;
    sel_idx = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (grant_vec[i]) begin
        sel_op  = op_arr[i];
        sel_a   = a_arr[i];
        sel_b   = b_arr[i];
        sel_idx = IDX_W'(i);
      end
    end
  end
  assign sel_tag = TAG_W'(TAG_BASE) + TAG_W'(sel_idx);

  always_comb begin
    rel_vec = '0;
    if (res_valid && res_ready) rel_vec[ex_idx] = 1'b1;
  end

  generate
    for (genvar g = 0; g < NUM_RS; g++) begin : g_st
      rs_station #(.DATA_W(DATA_W), .TAG_W(TAG_W)) st_i (
        .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[g]),
        .iss_op(iss_op), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
        .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .dispatch(disp_vec[g]), .release_i(rel_vec[g]),
        .busy_o(busy_vec[g]), .ready_o(ready_vec[g]),
        .op_o(op_arr[g]), .a_o(a_arr[g]), .b_o(b_arr[g])
      );
    end
  endgenerate

  rs_exec #(.DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) exec_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(sel_op), .a(sel_a), .b(sel_b),
    .tag(sel_tag), .idx(sel_idx), .res_ready(res_ready), .res_valid(res_valid),
    .res_tag(res_tag), .res_data(res_data), .res_idx(ex_idx)
  );

  assert_one_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy_vec) <= $past($countones(busy_vec)) + 1);
  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |=> ($countones(busy_vec) <= $past($countones(busy_vec))));
  assert_tag_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_tag) >= TAG_BASE && int'(res_tag) < TAG_BASE + NUM_RS));
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !busy_vec[$past(ex_idx)]);
endmodule

// File: tb/rs_pool_tb_top.sv
module rs_pool_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0;
  logic          iss_ready;
  logic [2:0]    iss_op = '0;
  logic [DW-1:0] iss_a_val = '0, iss_b_val = '0;
  logic [TW-1:0] iss_a_tag = '0, iss_b_tag = '0;
  logic          ext_v = 1'b0;
  logic [TW-1:0] ext_tag = '0;
  logic [DW-1:0] ext_data = '0;
  logic          allow = 1'b1;
  logic          bus_valid, res_valid, res_ready;
  logic [TW-1:0] bus_tag, res_tag;
  logic [DW-1:0] bus_data, res_data;

  int checks = 0;
  int fails  = 0;
  logic [TW-1:0] q_tag [$];
  logic [DW-1:0] q_data[$];
  string         q_req [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench arbiter: foreign producers win, the pool's result gets the bus otherwise
  assign res_ready = !ext_v && allow;
  assign bus_valid = ext_v || (res_valid && res_ready);
  assign bus_tag   = ext_v ? ext_tag : res_tag;
  assign bus_data  = ext_v ? ext_data : res_data;

  rs_pool #(.NUM_RS(N), .DATA_W(DW), .TAG_W(TW), .TAG_BASE(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
    .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_tag(res_tag), .res_data(res_data)
  );

  function automatic logic [DW-1:0] model(input logic [2:0] op, input logic [DW-1:0] a, b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return a;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_res(input logic [TW-1:0] t, input logic [DW-1:0] d, input string req);
    q_tag.push_back(t);
    q_data.push_back(d);
    q_req.push_back(req);
  endtask

  // monitor: every accepted result is compared with the front of the queue
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (q_tag.size() == 0) begin
        chk(1'b0, "R6", "unexpected result tag", 64'(res_tag), 64'(0));
      end else begin
        logic [TW-1:0] et;
        logic [DW-1:0] ed;
        string         er;
        et = q_tag.pop_front();
        ed = q_data.pop_front();
        er = q_req.pop_front();
        chk(res_tag == et, er, "result tag (R3)", 64'(res_tag), 64'(et));
        chk(res_data == ed, er, "result data", 64'(res_data), 64'(ed));
      end
    end
  end

  // called just after a rising edge; returns just after the accepting edge
  task automatic issue(input logic [2:0] op, input logic [DW-1:0] av, input logic [TW-1:0] at,
                       input logic [DW-1:0] bv, input logic [TW-1:0] bt);
    iss_valid = 1'b1;
    iss_op = op; iss_a_val = av; iss_a_tag = at; iss_b_val = bv; iss_b_tag = bt;
    do @(negedge clk); while (!iss_ready);
    @(posedge clk); #1;
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] d);
    ext_v = 1'b1; ext_tag = t; ext_data = d;
    @(posedge clk); #1;
    ext_v = 1'b0;
  endtask

  task automatic drain();
    while (q_tag.size() != 0) begin
      @(posedge clk); #1;
    end
    repeat (2) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 64'(0), 64'(1));
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(iss_ready == 1'b1, "R1", "iss_ready after reset", 64'(iss_ready), 64'(1));
    chk(res_valid == 1'b0, "R1", "res_valid after reset", 64'(res_valid), 64'(0));
    @(posedge clk); #1;

    // R10: each operation, pool empty so station 0 (tag 1)
    for (int k = 0; k < 6; k++) begin
      logic [DW-1:0] a, b;
      a = 32'hF0F0_1234 + 32'(k * 77);
      b = 32'h0FF0_0101 + 32'(k * 3);
      expect_res(4'd1, model(3'(k), a, b), "R10");
      issue(3'(k), a, 4'd0, b, 4'd0);
      drain();
    end

    // R4: chain inside the pool, second waits on first's tag
    expect_res(4'd1, 32'd12, "R4");
    expect_res(4'd2, 32'd15, "R4");
    issue(3'd0, 32'd5, 4'd0, 32'd7, 4'd0);
    issue(3'd0, 32'd0, 4'd1, 32'd3, 4'd0);
    drain();

    // R4: operands fill one at a time, foreign tag ignored
    issue(3'd1, 32'd0, 4'd12, 32'd0, 4'd13);
    bcast(4'd14, 32'd99);
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R4", "unmatched tag fired station", 64'(res_valid), 64'(0));
    @(posedge clk); #1;
    bcast(4'd13, 32'd2);
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R4", "fired with one operand", 64'(res_valid), 64'(0));
    @(posedge clk); #1;
    expect_res(4'd1, 32'd48, "R4");
    bcast(4'd12, 32'd50);
    drain();

    // R5: broadcast in the same cycle as issue
    expect_res(4'd1, 32'd21, "R5");
    fork
      issue(3'd0, 32'd0, 4'd9, 32'd1, 4'd0);
      bcast(4'd9, 32'd20);
    join
    drain();

    // R7: re-allocated station 0 is younger than station 1
    expect_res(4'd3, 32'd7, "R7");
    issue(3'd0, 32'd0, 4'd10, 32'd1, 4'd0);
    issue(3'd0, 32'd0, 4'd9, 32'd2, 4'd0);
    issue(3'd0, 32'd3, 4'd0, 32'd4, 4'd0);
    drain();
    expect_res(4'd1, 32'd31, "R7");
    bcast(4'd10, 32'd30);
    drain();
    issue(3'd0, 32'd0, 4'd9, 32'd3, 4'd0);
    expect_res(4'd2, 32'd102, "R7");
    expect_res(4'd1, 32'd103, "R7");
    bcast(4'd9, 32'd100);
    drain();

    // R8: result held under back-pressure
    allow = 1'b0;
    expect_res(4'd1, 32'h0000_0F00, "R8");
    issue(3'd2, 32'h0000_FF00, 4'd0, 32'h0000_0FF0, 4'd0);
    @(posedge clk); #1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(res_valid == 1'b1, "R8", "res_valid held", 64'(res_valid), 64'(1));
      chk(res_data == 32'h0000_0F00, "R8", "res_data held", 64'(res_data), 64'h0F00);
    end
    @(posedge clk); #1;
    allow = 1'b1;
    drain();

    // R2: fill the pool, hold a fifth instruction
    for (int k = 0; k < N; k++) issue(3'd0, 32'd0, 4'd9, 32'(k), 4'd0);
    @(negedge clk);
    chk(iss_ready == 1'b0, "R2", "iss_ready with pool full", 64'(iss_ready), 64'(0));
    @(posedge clk); #1;
    fork
      issue(3'd1, 32'd50, 4'd0, 32'd8, 4'd0);
      begin
        repeat (3) begin
          @(negedge clk);
          chk(iss_ready == 1'b0, "R2", "iss_ready while stalled", 64'(iss_ready), 64'(0));
          chk(res_valid == 1'b0, "R2", "result while all waiting", 64'(res_valid), 64'(0));
        end
        @(posedge clk); #1;
        for (int k = 0; k < N; k++) expect_res(4'(k + 1), 32'(200 + k), "R2");
        expect_res(4'd1, 32'd42, "R2");
        bcast(4'd9, 32'd200);
      end
    join
    drain();

    // R9: every station is reusable after release
    @(negedge clk);
    chk(iss_ready == 1'b1, "R9", "iss_ready after drain", 64'(iss_ready), 64'(1));
    @(posedge clk); #1;
    for (int k = 0; k < N; k++) issue(3'd4, 32'd0, 4'd11, 32'(k), 4'd0);
    @(negedge clk);
    chk(iss_ready == 1'b0, "R9", "all stations re-allocated", 64'(iss_ready), 64'(0));
    @(posedge clk); #1;
    for (int k = 0; k < N; k++) expect_res(4'(k + 1), 32'h55 ^ 32'(k), "R9");
    bcast(4'd11, 32'h55);
    drain();

    chk(q_tag.size() == 0, "R6", "results outstanding", 64'(q_tag.size()), 64'(0));
    finish_run();
  end
endmodule